// File: doc/BRIEF.md
# Linked-Descriptor Source DMA Channel

This block is the source half of a DMA channel. It follows a chain of descriptors held in local memory and feeds a 32-bit outbound FIFO. For each descriptor it reads a flags/address word and a word count. It then forwards a four-word header, which sits in memory right behind those two words, into the FIFO. After the header it streams the payload that the descriptor points to. The chain ends when a descriptor whose stop flags are set has been fully drained. At that point the channel turns itself off and pulses a completion interrupt.

Software, or a neighbouring controller, loads the first descriptor address and sets the enable. It then waits for the interrupt. Clearing the enable part-way through freezes the walk. Setting it again resumes the walk exactly where it stopped. Memory is read through a synchronous port whose data returns one cycle after the request. The FIFO reports its free space, and the channel never writes more words than it has room for.

Top module: `chain_src_dma`

## Requirements
- R1: While reset is asserted and just after it is released, `busy_o`, `push_o`, `irq_o` and `mem_re_o` are all low.
- R2: A descriptor at byte address T is read as follows. The flags word is at T and the word count is at T+4. Then the four words at T+8, T+12, T+16 and T+20 are pushed into the FIFO in that order, before any payload word of that descriptor.
- R3: The word count is rounded up to the next multiple of 4 before use, so a count of 0 moves no payload words.
- R4: Payload words are read from consecutive word addresses. The first address is the low 24 bits of the flags word; bits 31:24 do not take part in the address.
- R5: Once a descriptor has been fetched, the next descriptor is taken from T+16, whatever the payload length.
- R6: The channel stops when two conditions hold: the remaining count is zero, and bit 31 or bit 30 of the last flags word is 1. On stopping, `busy_o` falls and `irq_o` is high for exactly one cycle. This happens only after the last word of the chain has been pushed.
- R7: With a zero remaining count and no stop flag, the next descriptor is read only when at least 4 words of FIFO space remain. While fewer are free, `mem_re_o` stays low.
- R8: At most one word is pushed per cycle. A push never occurs when `fifo_free_i` is 0. Each pushed word is the memory read data returned one cycle after a read.
- R9: A write with `ctl_wr_i`=1 copies `ctl_en_i` into the enable, which is seen on `busy_o`. While the enable is low, no read is issued, and only a read already in flight is pushed. Setting the enable again continues the same word stream with nothing lost or repeated.
- R10: The stop flags are cleared when the channel stops. A later enable with no new `tag_wr_i` therefore fetches a fresh descriptor at the last descriptor address plus 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr_i | input | 1 | Enable write strobe |
| ctl_en_i | input | 1 | Enable value written on `ctl_wr_i` |
| tag_wr_i | input | 1 | Load strobe for the descriptor address |
| tag_addr_i | input | AW | Byte address of the first descriptor |
| busy_o | output | 1 | Channel enable state |
| irq_o | output | 1 | One-cycle completion pulse |
| mem_re_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory byte address |
| mem_rdata_i | input | 32 | Read data, valid one cycle after `mem_re_o` |
| fifo_free_i | input | FREE_W | Free words in the outbound FIFO |
| push_o | output | 1 | FIFO push strobe |
| push_data_o | output | 32 | FIFO push data |

## Verification
Each pushed word follows its memory read by exactly one cycle. The interrupt and the fall of `busy_o` come on the edge after the sequencer sees a zero count with a stop flag and no read in flight. That is at least one cycle after the final push. An enable or tag write takes effect on the following edge.

The bench drives and samples on falling edges, so every registered result has settled. It waits on an interrupt counter rather than a fixed cycle count, because arrival depends on the FIFO drain pattern. For the pause, it skips the two cycles in which an in-flight read may still complete before it requires silence. The whole pushed stream is compared against one rebuilt arithmetically from the memory image and the descriptor rules.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

   // what a returning read carries
   typedef enum logic [2:0] {
      RK_NONE,
      RK_FLAGS,
      RK_COUNT,
      RK_HDR,
      RK_DATA
   } rd_kind_e;

   // sequencer position
   typedef enum logic [2:0] {
      ST_CHECK,
      ST_TAG0,
      ST_TAG1,
      ST_HDR,
      ST_DATA
   } seq_st_e;

endpackage

// File: rtl/cdma_track.sv
module cdma_track
   import cdma_pkg::*;
#(
   parameter int unsigned FREE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_kind_e          issue_i,
   input  logic [31:0]       rdata_i,
   input  logic [FREE_W-1:0] fifo_free_i,
   output logic              push_o,
   output logic [31:0]       push_data_o,
   output logic              cap_flags_o,
   output logic              cap_count_o,
   output logic              inflight_o
);

   rd_kind_e rk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) rk_q <= RK_NONE;
      else        rk_q <= issue_i;
   end

   always_comb begin
      push_o      = (rk_q == RK_HDR) || (rk_q == RK_DATA);
      push_data_o = rdata_i;
      cap_flags_o = (rk_q == RK_FLAGS);
      cap_count_o = (rk_q == RK_COUNT);
      inflight_o  = (rk_q != RK_NONE);
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> (fifo_free_i != '0));

endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
   import cdma_pkg::*;
#(
   parameter int unsigned FREE_W = 8,
   parameter int unsigned HDR_W  = 4,
   parameter int unsigned IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic              ctl_en_i,
   input  logic [FREE_W-1:0] fifo_free_i,
   input  logic              push_now_i,
   input  logic              inflight_i,
   input  logic              cnt_zero_i,
   input  logic              stop_flag_i,
   output logic              enable_o,
   output logic              irq_o,
   output logic              clr_flags_o,
   output rd_kind_e          issue_o,
   output logic [IDX_W-1:0]  hdr_idx_o
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_W - 1);

   seq_st_e           st_q, st_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic              en_q, irq_q, stop;
   logic [FREE_W-1:0] free_eff;
   logic              room, hdr_room;

   always_comb begin
      free_eff = fifo_free_i - FREE_W'(push_now_i);
      room     = (free_eff != '0);
      hdr_room = (free_eff >= FREE_W'(HDR_W));
      st_d     = st_q;
      idx_d    = idx_q;
      issue_o  = RK_NONE;
      stop     = 1'b0;
      if (en_q) begin
         unique case (st_q)
            ST_CHECK: begin
               if (!cnt_zero_i)      st_d = ST_DATA;
               else if (stop_flag_i) stop = !inflight_i;
               else if (hdr_room)    st_d = ST_TAG0;
            end
            ST_TAG0: begin
               issue_o = RK_FLAGS;
               st_d    = ST_TAG1;
            end
            ST_TAG1: begin
               issue_o = RK_COUNT;
               st_d    = ST_HDR;
               idx_d   = '0;
            end
            ST_HDR: begin
               if (room) begin
                  issue_o = RK_HDR;
                  if (idx_q == LAST_IDX) st_d = ST_DATA;
                  else                   idx_d = idx_q + IDX_W'(1);
               end
            end
            ST_DATA: begin
               if (cnt_zero_i) st_d    = ST_CHECK;
               else if (room)  issue_o = RK_DATA;
            end
            default: st_d = ST_CHECK;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_CHECK;
         idx_q <= '0;
         en_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         irq_q <= stop;
         if (stop)          en_q <= 1'b0;
         else if (ctl_wr_i) en_q <= ctl_en_i;
      end
   end

   assign enable_o    = en_q;
   assign irq_o       = irq_q;
   assign clr_flags_o = stop;
   assign hdr_idx_o   = idx_q;

   // R6
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R6
   stop_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !enable_o);

endmodule

// File: rtl/cdma_regs.sv
module cdma_regs
   import cdma_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned CNT_W      = 24,
   parameter int unsigned PADDR_W    = 24,
   parameter int unsigned GRAN       = 4,
   parameter int unsigned TAG_STRIDE = 16,
   parameter int unsigned IDX_W      = 2,
   parameter int unsigned HDR_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tag_wr_i,
   input  logic [AW-1:0]    tag_addr_i,
   input  rd_kind_e         issue_i,
   input  logic [IDX_W-1:0] hdr_idx_i,
   input  logic             cap_flags_i,
   input  logic             cap_count_i,
   input  logic             clr_flags_i,
   input  logic [31:0]      rdata_i,
   output logic [AW-1:0]    mem_addr_o,
   output logic             cnt_zero_o,
   output logic             stop_flag_o
);

   localparam int unsigned    HDR_OFS  = 8;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(HDR_W - 1);

   logic [AW-1:0]    tadr_q, madr_q;
   logic [31:0]      flags_q;
   logic [CNT_W-1:0] cnt_q;
   logic [31:0]      cnt_round;

   generate
      if (GRAN == 1) begin : g_exact
         assign cnt_round = rdata_i;
      end else begin : g_round
         if ((GRAN & (GRAN - 1)) != 0) begin : g_bad_gran
            $error("GRAN must be a power of two");
         end
         assign cnt_round = (rdata_i + 32'(GRAN - 1)) & ~32'(GRAN - 1);
      end
   endgenerate

   always_comb begin
      unique case (issue_i)
         RK_FLAGS: mem_addr_o = tadr_q;
         RK_COUNT: mem_addr_o = tadr_q + AW'(4);
         RK_HDR:   mem_addr_o = tadr_q + AW'(HDR_OFS) + (AW'(hdr_idx_i) << 2);
         RK_DATA:  mem_addr_o = madr_q;
         default:  mem_addr_o = tadr_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tadr_q  <= '0;
         madr_q  <= '0;
         flags_q <= '0;
         cnt_q   <= '0;
      end else begin
         if (tag_wr_i)
            tadr_q <= tag_addr_i;
         else if (issue_i == RK_HDR && hdr_idx_i == LAST_IDX)
            tadr_q <= tadr_q + AW'(TAG_STRIDE);

         if (cap_flags_i)
            madr_q <= AW'(rdata_i[PADDR_W-1:0]);
         else if (issue_i == RK_DATA)
            madr_q <= madr_q + AW'(4);

         if (clr_flags_i)      flags_q <= '0;
         else if (cap_flags_i) flags_q <= rdata_i;

         if (cap_count_i)
            cnt_q <= cnt_round[CNT_W-1:0];
         else if (issue_i == RK_DATA)
            cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign cnt_zero_o  = (cnt_q == '0);
   assign stop_flag_o = flags_q[31] | flags_q[30];

   // R3
   round_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_count_i |=> ((cnt_q & CNT_W'(GRAN - 1)) == '0));

   // R4
   data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i == RK_DATA && $past(issue_i == RK_DATA)) |->
         (mem_addr_o == $past(mem_addr_o) + AW'(4)));

endmodule

// File: rtl/chain_src_dma.sv
module chain_src_dma
   import cdma_pkg::*;
#(
   parameter int unsigned AW         = 32,
   parameter int unsigned CNT_W      = 24,
   parameter int unsigned PADDR_W    = 24,
   parameter int unsigned FIFO_DEPTH = 128,
   parameter int unsigned HDR_W      = 4,
   parameter int unsigned GRAN       = 4,
   parameter int unsigned TAG_STRIDE = 16,
   localparam int unsigned FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic              ctl_en_i,
   input  logic              tag_wr_i,
   input  logic [AW-1:0]     tag_addr_i,
   output logic              busy_o,
   output logic              irq_o,
   output logic              mem_re_o,
   output logic [AW-1:0]     mem_addr_o,
   input  logic [31:0]       mem_rdata_i,
   input  logic [FREE_W-1:0] fifo_free_i,
   output logic              push_o,
   output logic [31:0]       push_data_o
);

   localparam int unsigned IDX_W = $clog2(HDR_W);

   generate
      if (HDR_W < 2) begin : g_bad_hdr
         $error("HDR_W must be at least 2");
      end
      if (FIFO_DEPTH < HDR_W) begin : g_bad_depth
         $error("FIFO_DEPTH must hold a full header");
      end
      if (AW < PADDR_W || PADDR_W > 32) begin : g_bad_aw
         $error("PADDR_W must fit in AW and in a 32-bit word");
      end
      if (CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must not exceed 32");
      end
   endgenerate

   rd_kind_e         issue;
   logic [IDX_W-1:0] hdr_idx;
   logic             cap_flags, cap_count, inflight, clr_flags;
   logic             cnt_zero, stop_flag;

   cdma_seq #(
      .FREE_W (FREE_W),
      .HDR_W  (HDR_W),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr_i    (ctl_wr_i),
      .ctl_en_i    (ctl_en_i),
      .fifo_free_i (fifo_free_i),
      .push_now_i  (push_o),
      .inflight_i  (inflight),
      .cnt_zero_i  (cnt_zero),
      .stop_flag_i (stop_flag),
      .enable_o    (busy_o),
      .irq_o       (irq_o),
      .clr_flags_o (clr_flags),
      .issue_o     (issue),
      .hdr_idx_o   (hdr_idx)
   );

   cdma_regs #(
      .AW         (AW),
      .CNT_W      (CNT_W),
      .PADDR_W    (PADDR_W),
      .GRAN       (GRAN),
      .TAG_STRIDE (TAG_STRIDE),
      .IDX_W      (IDX_W),
      .HDR_W      (HDR_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .tag_wr_i    (tag_wr_i),
      .tag_addr_i  (tag_addr_i),
      .issue_i     (issue),
      .hdr_idx_i   (hdr_idx),
      .cap_flags_i (cap_flags),
      .cap_count_i (cap_count),
      .clr_flags_i (clr_flags),
      .rdata_i     (mem_rdata_i),
      .mem_addr_o  (mem_addr_o),
      .cnt_zero_o  (cnt_zero),
      .stop_flag_o (stop_flag)
   );

   cdma_track #(
      .FREE_W (FREE_W)
   ) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_i     (issue),
      .rdata_i     (mem_rdata_i),
      .fifo_free_i (fifo_free_i),
      .push_o      (push_o),
      .push_data_o (push_data_o),
      .cap_flags_o (cap_flags),
      .cap_count_o (cap_count),
      .inflight_o  (inflight)
   );

   assign mem_re_o = (issue != RK_NONE);

   // R8
   push_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> $past(mem_re_o));

   // R9
   pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o)) |-> !push_o);

endmodule

// File: tb/test_chain_src_dma.sv
`timescale 1ns/1ps
module test_chain_src_dma;

   localparam int DEPTH  = 128;
   localparam int FREE_W = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ctl_wr = 1'b0, ctl_en = 1'b0, tag_wr = 1'b0;
   logic [31:0]       tag_addr = '0;
   logic              busy, irq, mem_re, push;
   logic [31:0]       mem_addr, push_data;
   logic [31:0]       rdata = '0;
   logic [FREE_W-1:0] fifo_free;

   always #4 clk = ~clk;

   chain_src_dma i_chain_src_dma (
      .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_en_i(ctl_en),
      .tag_wr_i(tag_wr), .tag_addr_i(tag_addr), .busy_o(busy), .irq_o(irq),
      .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
      .fifo_free_i(fifo_free), .push_o(push), .push_data_o(push_data)
   );

   logic [31:0] mem [logic [31:0]];
   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : ~a;
   endfunction

   always @(posedge clk) rdata <= mem_re ? rd(mem_addr) : 32'h0;

   int drain_mode = 1, preload_val = 0, ovf = 0, irq_cnt = 0, cyc = 0, occ = 0;
   bit preload_req = 1'b0;
   logic [31:0] got[$];
   logic [31:0] exp_q[$];

   always @(posedge clk) begin : sink
      int pop;
      pop = 0;
      cyc <= cyc + 1;
      if (irq) irq_cnt <= irq_cnt + 1;
      if (occ > 0 && (drain_mode == 1 || (drain_mode == 2 && cyc % 3 == 0))) pop = 1;
      if (push) begin
         got.push_back(push_data);
         if (occ - pop >= DEPTH) ovf <= ovf + 1;
      end
      if (preload_req) occ <= preload_val;
      else             occ <= occ + (push ? 1 : 0) - pop;
   end
   assign fifo_free = FREE_W'(DEPTH - occ);

   int nchk = 0, nfail = 0;
   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exv);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exv);
      end
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] fl, input logic [31:0] c);
      mem[a]      = fl;
      mem[a + 4]  = c;
      mem[a + 8]  = 32'h4EAD_0000 | {16'h0, a[15:0]};
      mem[a + 12] = 32'h5EAD_0000 | {16'h0, a[15:0]};
   endtask

   // expected stream from the descriptor rules
   task automatic make_exp(input logic [31:0] t0);
      logic [31:0] t, f, c, n, p;
      exp_q.delete();
      t = t0;
      for (int d = 0; d < 64; d++) begin
         f = rd(t);
         c = rd(t + 4);
         for (int i = 0; i < 4; i++) exp_q.push_back(rd(t + 8 + 4 * i));
         n = ((c + 3) & 32'hFFFF_FFFC) & 32'h00FF_FFFF;
         p = f & 32'h00FF_FFFF;
         for (int k = 0; k < int'(n); k++) exp_q.push_back(rd(p + 4 * k));
         t = t + 16;
         if (f[31] | f[30]) break;
      end
   endtask

   task automatic start_chain(input logic [31:0] t, input bit load);
      @(negedge clk);
      tag_wr = load; tag_addr = t; ctl_wr = 1'b1; ctl_en = 1'b1;
      @(negedge clk);
      tag_wr = 1'b0; ctl_wr = 1'b0;
   endtask

   task automatic finish_cmp(input int base, input int irq0, input string req);
      int n, bad;
      n = 0;
      while (irq_cnt == irq0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      repeat (2) @(negedge clk);
      chk(irq_cnt == irq0 + 1, "R6", "interrupt pulses", irq_cnt - irq0, 1);
      chk(!busy, "R6", "busy after stop", busy, 0);
      chk(got.size() - base == exp_q.size(), req, "stream length",
          got.size() - base, exp_q.size());
      bad = -1;
      for (int i = 0; i < exp_q.size() && base + i < got.size(); i++)
         if (bad < 0 && got[base + i] !== exp_q[i]) bad = i;
      chk(bad < 0, req, "stream word", bad < 0 ? 0 : got[base + bad],
          bad < 0 ? 0 : exp_q[bad]);
   endtask

   task automatic run(input logic [31:0] t, input bit load, input int mode, input string req);
      int base, irq0;
      make_exp(t);
      drain_mode = mode;
      base = got.size();
      irq0 = irq_cnt;
      start_chain(t, load);
      finish_cmp(base, irq0, req);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin : main
      int base, irq0;
      bit quiet;
      repeat (3) @(negedge clk);
      // R1
      chk(!busy && !push && !irq && !mem_re, "R1", "outputs in reset",
          {busy, push, irq, mem_re}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !push && !irq && !mem_re, "R1", "outputs after reset",
          {busy, push, irq, mem_re}, 0);

      // sweep of single-descriptor chains: counts 0..9, junk in bits 29:24, both stop bits
      for (int len = 0; len < 10; len++) begin
         for (int m = 1; m <= 2; m++) begin
            logic [31:0] t, fl;
            t  = 32'h8000 + 32'(len * 64) + 32'(m * 32'h800);
            fl = ((len % 2 == 0) ? 32'h8000_0000 : 32'h4000_0000)
                 | (32'(len) << 24) | (32'h0001_0000 + 32'(len * 256));
            put_desc(t, fl, 32'(len));
            run(t, 1'b1, m, "R2/R3/R4");
         end
      end

      // multi-descriptor chain: stride 16 regardless of payload
      put_desc(32'hA000, 32'h1F02_0000, 5);
      put_desc(32'hA010, 32'h0002_1000, 0);
      put_desc(32'hA020, 32'h2A02_2000, 8);
      put_desc(32'hA030, 32'hC002_3000, 3);
      run(32'hA000, 1'b1, 1, "R5");
      chk(ovf == 0, "R8", "pushes into a full FIFO", ovf, 0);

      // R10: re-enable without loading a new tag
      put_desc(32'h9000, 32'h8000_2000, 7);
      put_desc(32'h9010, 32'h4000_3000, 2);
      run(32'h9000, 1'b1, 1, "R10");
      run(32'h9010, 1'b0, 2, "R10");

      // R7: fewer than 4 free words blocks the descriptor fetch
      put_desc(32'hB000, 32'h8004_0000, 4);
      make_exp(32'hB000);
      drain_mode = 0;
      repeat (20) @(negedge clk);
      preload_val = DEPTH - 3; preload_req = 1'b1;
      @(negedge clk);
      preload_req = 1'b0;
      base = got.size(); irq0 = irq_cnt;
      start_chain(32'hB000, 1'b1);
      quiet = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (mem_re) quiet = 1'b0;
      end
      chk(quiet, "R7", "read with 3 free words", quiet, 1);
      drain_mode = 1;
      finish_cmp(base, irq0, "R7");

      // R9: pause mid-stream, then resume
      put_desc(32'hC000, 32'h0005_0000, 20);
      put_desc(32'hC010, 32'h0005_1000, 20);
      put_desc(32'hC020, 32'h4005_2000, 20);
      make_exp(32'hC000);
      drain_mode = 2;
      base = got.size(); irq0 = irq_cnt;
      start_chain(32'hC000, 1'b1);
      repeat (25) @(negedge clk);
      ctl_wr = 1'b1; ctl_en = 1'b0;
      @(negedge clk);
      ctl_wr = 1'b0;
      @(negedge clk);
      chk(!busy, "R9", "busy while paused", busy, 0);
      quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (push || mem_re) quiet = 1'b0;
      end
      chk(quiet, "R9", "activity while paused", quiet, 1);
      chk(irq_cnt == irq0, "R9", "interrupt while paused", irq_cnt - irq0, 0);
      start_chain(32'hC000, 1'b0);
      finish_cmp(base, irq0, "R9");
      chk(ovf == 0, "R8", "pushes into a full FIFO", ovf, 0);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule